// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Condition Flags

This block is the execution stage for single-byte data operations. One operand comes from the destination register (`a_i`). The other (`b_i`) has already been chosen upstream, either from a second register or from an immediate. A 5-bit operation code selects the function. The result, a destination-write strobe, a flag-write strobe and a divide-error strobe are formed combinationally in the same cycle. Two condition flags, zero and negative, are held in a small register that loads on the clock edge when the flag-write strobe is high.

The surrounding pipeline writes `res_o` into the destination register when `wr_en_o` is high. It raises a fault when `div_err_o` is high. It reads `flags_o` for conditional branching. Flag bit 0 is zero and flag bit 1 is negative. Each flag load replaces both bits together. Compare changes only the flags. Nibble swap and the data-movement operations (increment, decrement, move) write a result and keep the flags as they are.

The data width is a parameter, with a default of 8. The divider and the multiplier each come in two variants, selected by parameter: the language operator, or an unrolled restoring or shift-add array.

Top module: `balu_core`

## Requirements
- R1: While `rst_ni` is low, and at the first edge after it is released, `flags_o` is 2'b00.
- R2: Arithmetic codes give results modulo 256: add (0) is a+b, subtract (1) is a-b, multiply (2) is the low 8 bits of a*b, and negate (5) is 0-a. Each has `wr_en_o`=1 and `flag_we_o`=1.
- R3: Logic codes are and (6), or (7), xor (8) and not (9), where not is ~a. Each has `wr_en_o`=1 and `flag_we_o`=1.
- R4: Shift codes are shift left (10), logical shift right (11) and arithmetic shift right (12), each by the amount `b_i`. Logical shifts fill with zeros. Arithmetic right shift fills with copies of a[7]. An amount of 8 or more gives 0 for the logical shifts and eight copies of a[7] for the arithmetic shift. Each has `wr_en_o`=1 and `flag_we_o`=1.
- R5: Divide (3) gives the unsigned quotient a/b, and modulo (4) gives the unsigned remainder a%b. For a nonzero `b_i`, both have `wr_en_o`=1 and `flag_we_o`=1.
- R6: Divide or modulo with `b_i`=0 gives `div_err_o`=1, `wr_en_o`=0 and `flag_we_o`=0, so the flags keep their value.
- R7: When `flag_we_o`=1 on an operation other than compare, the next `flags_o` is {res[7], res==0}.
- R8: Compare (14) gives `wr_en_o`=0 and `flag_we_o`=1. The next `flags_o` has zero = (a==b) and negative = (a<b as unsigned values), taken from a 9-bit difference.
- R9: Nibble swap (13) gives {a[3:0], a[7:4]} with `wr_en_o`=1 and `flag_we_o`=0.
- R10: Increment (15) gives a+1, decrement (16) gives a-1 and move (17) gives b, all modulo 256. Each has `wr_en_o`=1 and `flag_we_o`=0.
- R11: With `valid_i`=0, `wr_en_o`, `flag_we_o` and `div_err_o` are all 0 and `flags_o` holds its value.
- R12: Codes 18 to 31 are undefined. They give `wr_en_o`=0, `flag_we_o`=0 and `div_err_o`=0, and leave `flags_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the flag register |
| rst_ni | input | 1 | Active-low synchronous reset of the flags |
| valid_i | input | 1 | An operation is issued this cycle |
| op_i | input | 5 | Operation code |
| a_i | input | DATA_W | Destination operand |
| b_i | input | DATA_W | Second operand, a register value or an immediate |
| res_o | output | DATA_W | Operation result |
| wr_en_o | output | 1 | Write `res_o` to the destination |
| flag_we_o | output | 1 | Flags load at the next edge |
| div_err_o | output | 1 | Divide or modulo by zero |
| flags_o | output | 2 | Registered flags: bit 1 negative, bit 0 zero |

## Verification
The clocked assertions assume that `op_i`, `a_i` and `b_i` are stable around each rising edge. The stimulus therefore changes inputs only at odd nanosecond offsets, away from every edge. The divider identity and the arithmetic-shift sign check are taken only when the inputs carry no unknown bits, and the divider identity only for a nonzero divisor. The sweep visits all 32 operation codes with every value of `a_i`, against 30 values of `b_i` that include shift amounts 0 through 9 and a zero divisor. A directed sequence then follows the flag register through updates, holds, compares and idle cycles.

// File: rtl/balu_pkg.sv
package balu_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_SUB  = 5'd1,
      OP_MUL  = 5'd2,
      OP_DIV  = 5'd3,
      OP_MOD  = 5'd4,
      OP_NEG  = 5'd5,
      OP_AND  = 5'd6,
      OP_OR   = 5'd7,
      OP_XOR  = 5'd8,
      OP_NOT  = 5'd9,
      OP_SHL  = 5'd10,
      OP_SHR  = 5'd11,
      OP_SAR  = 5'd12,
      OP_SWAP = 5'd13,
      OP_CMP  = 5'd14,
      OP_INC  = 5'd15,
      OP_DEC  = 5'd16,
      OP_MOVE = 5'd17
   } balu_op_e;

   localparam int unsigned OP_W = 5;

   // Flag register layout: bit 1 negative, bit 0 zero.
   typedef struct packed {
      logic neg;
      logic zero;
   } balu_flags_t;

endpackage

// File: rtl/balu_addsub.sv
module balu_addsub
   import balu_pkg::*;
#(
   parameter int unsigned W             = 8,
   parameter bit          MUL_SHIFT_ADD = 1'b1
) (
   input  balu_op_e       op_i,
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   output logic [W-1:0]   res_o,
   output logic           cmp_zero_o,
   output logic           cmp_neg_o
);

   localparam int unsigned WX = W + 1;

   logic [W-1:0]  mul_r;
   logic [WX-1:0] diff_x;

   // Product keeps only the low W bits.
   generate
      if (MUL_SHIFT_ADD) begin : g_mul_array
         always_comb begin
            logic [W-1:0] acc;
            acc = '0;
            for (int i = 0; i < int'(W); i++) begin
               if (b_i[i]) acc = acc + (a_i << i);
            end
            mul_r = acc;
         end
      end else begin : g_mul_op
         assign mul_r = a_i * b_i;
      end
   endgenerate

   // Compare works at one extra bit so the borrow shows unsigned order.
   assign diff_x     = {1'b0, a_i} - {1'b0, b_i};
   assign cmp_zero_o = (diff_x == '0);
   assign cmp_neg_o  = diff_x[W];

   always_comb begin
      case (op_i)
         OP_ADD:  res_o = a_i + b_i;
         OP_SUB:  res_o = diff_x[W-1:0];
         OP_MUL:  res_o = mul_r;
         OP_NEG:  res_o = '0 - a_i;
         OP_INC:  res_o = a_i + W'(1);
         OP_DEC:  res_o = a_i - W'(1);
         default: res_o = diff_x[W-1:0];
      endcase
   end

endmodule

// File: rtl/balu_divider.sv
module balu_divider #(
   parameter int unsigned W        = 8,
   parameter bit          DIV_LOOP = 1'b1
) (
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic [W-1:0] quo_o,
   output logic [W-1:0] rem_o,
   output logic         dz_o
);

   localparam int unsigned W2 = 2 * W;

   assign dz_o = (divisor_i == '0);

   generate
      if (DIV_LOOP) begin : g_restoring
         // One trial subtraction per quotient bit, most significant first.
         always_comb begin
            logic [W-1:0] rem_v;
            logic [W:0]   trial;
            quo_o = '0;
            rem_v = '0;
            for (int i = int'(W) - 1; i >= 0; i--) begin
               trial = {rem_v, dividend_i[i]};
               if (trial >= {1'b0, divisor_i}) begin
                  rem_v    = W'(trial - {1'b0, divisor_i});
                  quo_o[i] = 1'b1;
               end else begin
                  rem_v = trial[W-1:0];
               end
            end
            rem_o = rem_v;
         end
      end else begin : g_operator
         assign quo_o = dz_o ? '0 : dividend_i / divisor_i;
         assign rem_o = dz_o ? '0 : dividend_i % divisor_i;
      end
   endgenerate

   // R5: quotient and remainder rebuild the dividend, and the remainder is below the divisor
   always_comb begin
      if (!$isunknown({dividend_i, divisor_i}) && !dz_o) begin
         p_div_identity_r5: assert ((W2'(quo_o) * W2'(divisor_i) + W2'(rem_o)) == W2'(dividend_i)
                                    && rem_o < divisor_i)
            else $error("divider identity broken");
      end
   end

endmodule

// File: rtl/balu_bitops.sv
module balu_bitops
   import balu_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  balu_op_e     op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] res_o
);

   localparam int unsigned SH_W = $clog2(W);
   localparam int unsigned HALF = W / 2;

   logic              shift_big;
   logic [SH_W-1:0]   shamt;
   logic [W-1:0]      shl_r;
   logic [W-1:0]      shr_r;
   logic [W-1:0]      sar_r;
   logic [W-1:0]      swap_r;

   // Any amount of W or more empties the word.
   assign shift_big = ({1'b0, b_i} >= (W+1)'(W));
   assign shamt     = b_i[SH_W-1:0];

   assign shl_r  = shift_big ? '0 : (a_i << shamt);
   assign shr_r  = shift_big ? '0 : (a_i >> shamt);
   assign sar_r  = shift_big ? {W{a_i[W-1]}} : W'($signed(a_i) >>> shamt);

   // Exchange the two halves of the word.
   genvar gi;
   generate
      for (gi = 0; gi < int'(HALF); gi++) begin : g_swap
         assign swap_r[gi]        = a_i[gi + HALF];
         assign swap_r[gi + HALF] = a_i[gi];
      end
   endgenerate

   always_comb begin
      case (op_i)
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         OP_NOT:  res_o = ~a_i;
         OP_SHL:  res_o = shl_r;
         OP_SHR:  res_o = shr_r;
         OP_SAR:  res_o = sar_r;
         OP_SWAP: res_o = swap_r;
         default: res_o = b_i;
      endcase
   end

   // R4: arithmetic right shift never changes the sign bit
   always_comb begin
      if (op_i == OP_SAR && !$isunknown({a_i, b_i})) begin
         p_sar_sign_r4: assert (res_o[W-1] == a_i[W-1])
            else $error("arithmetic shift lost the sign");
      end
   end

endmodule

// File: rtl/balu_core.sv
module balu_core
   import balu_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter bit          DIV_LOOP      = 1'b1,
   parameter bit          MUL_SHIFT_ADD = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic [4:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o,
   output logic              wr_en_o,
   output logic              flag_we_o,
   output logic              div_err_o,
   output logic [1:0]        flags_o
);

   localparam int unsigned MSB = DATA_W - 1;

   generate
      if (DATA_W < 4 || DATA_W > 16 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("balu_core: DATA_W must be even and within 4..16");
      end
      if (OP_W != 5) begin : g_bad_opw
         $error("balu_core: operation code width mismatch");
      end
   endgenerate

   balu_op_e          op;
   logic [DATA_W-1:0] arith_r;
   logic [DATA_W-1:0] bit_r;
   logic [DATA_W-1:0] quo_r;
   logic [DATA_W-1:0] rem_r;
   logic              dz;
   logic              cmp_zero;
   logic              cmp_neg;
   logic              wr_raw;
   logic              fwe_raw;
   logic              err_raw;
   logic              is_cmp;
   balu_flags_t       flags_d;
   balu_flags_t       flags_q;

   assign op = balu_op_e'(op_i);

   balu_addsub #(
      .W             (DATA_W),
      .MUL_SHIFT_ADD (MUL_SHIFT_ADD)
   ) u_addsub (
      .op_i       (op),
      .a_i        (a_i),
      .b_i        (b_i),
      .res_o      (arith_r),
      .cmp_zero_o (cmp_zero),
      .cmp_neg_o  (cmp_neg)
   );

   balu_divider #(
      .W        (DATA_W),
      .DIV_LOOP (DIV_LOOP)
   ) u_divider (
      .dividend_i (a_i),
      .divisor_i  (b_i),
      .quo_o      (quo_r),
      .rem_o      (rem_r),
      .dz_o       (dz)
   );

   balu_bitops #(
      .W (DATA_W)
   ) u_bitops (
      .op_i  (op),
      .a_i   (a_i),
      .b_i   (b_i),
      .res_o (bit_r)
   );

   // Result selection and strobe classes per operation.
   always_comb begin
      res_o   = '0;
      wr_raw  = 1'b0;
      fwe_raw = 1'b0;
      err_raw = 1'b0;
      is_cmp  = 1'b0;
      case (op)
         OP_ADD, OP_SUB, OP_MUL, OP_NEG: begin
            res_o   = arith_r;
            wr_raw  = 1'b1;
            fwe_raw = 1'b1;
         end
         OP_DIV, OP_MOD: begin
            res_o   = (op == OP_DIV) ? quo_r : rem_r;
            wr_raw  = !dz;
            fwe_raw = !dz;
            err_raw = dz;
         end
         OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SHL, OP_SHR, OP_SAR: begin
            res_o   = bit_r;
            wr_raw  = 1'b1;
            fwe_raw = 1'b1;
         end
         OP_SWAP, OP_MOVE: begin
            res_o  = bit_r;
            wr_raw = 1'b1;
         end
         OP_INC, OP_DEC: begin
            res_o  = arith_r;
            wr_raw = 1'b1;
         end
         OP_CMP: begin
            res_o   = arith_r;
            fwe_raw = 1'b1;
            is_cmp  = 1'b1;
         end
         default: begin
            res_o = '0;
         end
      endcase
   end

   assign wr_en_o   = valid_i && wr_raw;
   assign flag_we_o = valid_i && fwe_raw;
   assign div_err_o = valid_i && err_raw;

   // Both flags are rebuilt on every load.
   always_comb begin
      if (is_cmp) begin
         flags_d.zero = cmp_zero;
         flags_d.neg  = cmp_neg;
      end else begin
         flags_d.zero = (res_o == '0);
         flags_d.neg  = res_o[MSB];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         flags_q <= '0;
      end else if (flag_we_o) begin
         flags_q <= flags_d;
      end
   end

   assign flags_o = flags_q;

   // R1: reset clears the flags
   p_reset_clear_r1: assert property (@(posedge clk_i) !rst_ni |=> flags_o == 2'b00)
      else $error("flags not cleared by reset");

   // R7: a flag load follows the written result
   p_flags_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_we_o && op != OP_CMP) |=>
         (flags_o[0] == ($past(res_o) == '0)) && (flags_o[1] == $past(res_o[MSB])))
      else $error("flags do not match the result");

   // R8: compare loads unsigned order and equality, and writes nothing
   p_cmp_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op == OP_CMP) |=>
         (flags_o[0] == ($past(a_i) == $past(b_i))) && (flags_o[1] == ($past(a_i) < $past(b_i))))
      else $error("compare flags wrong");

   p_cmp_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op == OP_CMP) |-> (!wr_en_o && flag_we_o))
      else $error("compare strobes wrong");

   // R6: a zero divisor suppresses both writes
   p_div_zero_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_err_o |-> (!wr_en_o && !flag_we_o && b_i == '0))
      else $error("divide error with a write");

   // R11: flags hold whenever no load is requested
   p_flags_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flag_we_o |=> $stable(flags_o))
      else $error("flags changed without a load");

   p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |-> (!wr_en_o && !flag_we_o && !div_err_o))
      else $error("strobe while idle");

   // R12: undefined codes stay silent
   p_undef_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i > 5'd17) |-> $onehot0({wr_en_o, flag_we_o, div_err_o}) && !wr_en_o && !flag_we_o && !div_err_o)
      else $error("undefined code produced a strobe");

endmodule

// File: tb/balu_core_tb_top.sv
`timescale 1ns/1ps
module balu_core_tb_top;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       valid_i = 1'b0;
   logic [4:0] op_i = '0;
   logic [7:0] a_i = '0;
   logic [7:0] b_i = '0;
   logic [7:0] res_o;
   logic       wr_en_o;
   logic       flag_we_o;
   logic       div_err_o;
   logic [1:0] flags_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk_i = ~clk_i;

   balu_core dut_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (valid_i),
      .op_i      (op_i),
      .a_i       (a_i),
      .b_i       (b_i),
      .res_o     (res_o),
      .wr_en_o   (wr_en_o),
      .flag_we_o (flag_we_o),
      .div_err_o (div_err_o),
      .flags_o   (flags_o)
   );

   function automatic string tag_of(input int op);
      if (op <= 2 || op == 5) return "R2";
      if (op == 3 || op == 4) return "R5";
      if (op >= 6 && op <= 9) return "R3";
      if (op >= 10 && op <= 12) return "R4";
      if (op == 13) return "R9";
      if (op == 14) return "R8";
      if (op >= 15 && op <= 17) return "R10";
      return "R12";
   endfunction

   // Expected behaviour, computed from the requirements.
   task automatic model(input int op, input int a, input int b,
                        output int r, output bit wr, output bit fwe,
                        output bit err, output bit chk);
      int sa;
      r = 0; wr = 1'b1; fwe = 1'b1; err = 1'b0; chk = 1'b1;
      sa = (a >= 128) ? a - 256 : a;
      case (op)
         0:  r = (a + b) & 255;
         1:  r = (a - b) & 255;
         2:  r = (a * b) & 255;
         3, 4: begin
            if (b == 0) begin
               wr = 1'b0; fwe = 1'b0; err = 1'b1; chk = 1'b0;
            end else begin
               r = (op == 3) ? a / b : a % b;
            end
         end
         5:  r = (256 - a) & 255;
         6:  r = a & b;
         7:  r = a | b;
         8:  r = a ^ b;
         9:  r = 255 - a;
         10: r = (b >= 8) ? 0 : (a << b) & 255;
         11: r = (b >= 8) ? 0 : a >> b;
         12: r = (b >= 8) ? ((a >= 128) ? 255 : 0) : (sa >>> b) & 255;
         13: begin r = ((a & 15) << 4) | (a >> 4); fwe = 1'b0; end
         14: begin wr = 1'b0; chk = 1'b0; end
         15: begin r = (a + 1) & 255; fwe = 1'b0; end
         16: begin r = (a + 255) & 255; fwe = 1'b0; end
         17: begin r = b; fwe = 1'b0; end
         default: begin wr = 1'b0; fwe = 1'b0; chk = 1'b0; end
      endcase
   endtask

   task automatic check_flags(input logic [1:0] exp, input string tag);
      checks++;
      if (flags_o !== exp) begin
         errors++;
         $display("FAIL %s flags actual=%b expected=%b", tag, flags_o, exp);
      end
   endtask

   // Issue one operation for one clock and check the flags afterwards.
   task automatic issue(input int op, input int a, input int b, input bit v,
                        input logic [1:0] exp, input string tag);
      @(negedge clk_i);
      op_i = 5'(op); a_i = 8'(a); b_i = 8'(b); valid_i = v;
      @(posedge clk_i);
      #2;
      check_flags(exp, tag);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int  r;
      bit  wr, fwe, err, chk;
      int  bv;
      // R1: reset state
      repeat (3) @(posedge clk_i);
      #2;
      check_flags(2'b00, "R1");
      @(negedge clk_i);
      rst_ni = 1'b1;
      @(posedge clk_i);
      #2;
      check_flags(2'b00, "R1");

      // Sweep every code against all a values and a spread of b values.
      @(negedge clk_i);
      #1;
      valid_i = 1'b1;
      for (int op = 0; op < 32; op++) begin
         for (int bi = 0; bi < 30; bi++) begin
            bv = (bi < 10) ? bi : (bi * 37) % 256;
            for (int a = 0; a < 256; a++) begin
               op_i = 5'(op); a_i = 8'(a); b_i = 8'(bv);
               #1;
               model(op, a, bv, r, wr, fwe, err, chk);
               checks++;
               if ((chk && res_o !== 8'(r)) || wr_en_o !== wr ||
                   flag_we_o !== fwe || div_err_o !== err) begin
                  errors++;
                  $display("FAIL %s op=%0d a=%0d b=%0d actual res=%0d wr=%b fwe=%b err=%b expected res=%0d wr=%b fwe=%b err=%b",
                           tag_of(op), op, a, bv, res_o, wr_en_o, flag_we_o, div_err_o,
                           r, wr, fwe, err);
               end
               #1;
            end
         end
      end

      // Directed flag sequence.
      issue(0, 8'h80, 8'h80, 1'b1, 2'b01, "R7 add wraps to zero");
      issue(1, 3, 5, 1'b1, 2'b10, "R7 subtract negative");
      issue(13, 8'h12, 0, 1'b1, 2'b10, "R9 swap keeps flags");
      issue(15, 8'hFF, 0, 1'b1, 2'b10, "R10 increment keeps flags");
      issue(14, 5, 5, 1'b1, 2'b01, "R8 compare equal");
      issue(14, 3, 200, 1'b1, 2'b10, "R8 compare below");
      issue(14, 200, 3, 1'b1, 2'b00, "R8 compare above");
      issue(14, 1, 2, 1'b1, 2'b10, "R8 compare below");
      issue(3, 7, 0, 1'b1, 2'b10, "R6 divide by zero keeps flags");
      issue(4, 9, 0, 1'b1, 2'b10, "R6 modulo by zero keeps flags");
      issue(0, 0, 0, 1'b0, 2'b10, "R11 idle keeps flags");
      checks++;
      if (wr_en_o !== 1'b0 || flag_we_o !== 1'b0 || div_err_o !== 1'b0) begin
         errors++;
         $display("FAIL R11 idle strobes actual=%b%b%b expected=000", wr_en_o, flag_we_o, div_err_o);
      end
      issue(3, 9, 0, 1'b0, 2'b10, "R11 idle divide by zero");
      checks++;
      if (div_err_o !== 1'b0) begin
         errors++;
         $display("FAIL R11 idle error actual=%b expected=0", div_err_o);
      end
      issue(4, 200, 7, 1'b1, 2'b00, "R5 modulo updates flags");
      issue(14, 0, 1, 1'b1, 2'b10, "R8 compare below");
      issue(20, 0, 0, 1'b1, 2'b10, "R12 undefined keeps flags");
      issue(31, 255, 255, 1'b1, 2'b10, "R12 undefined keeps flags");
      issue(5, 0, 0, 1'b1, 2'b01, "R7 negate zero");
      issue(12, 8'h80, 1, 1'b1, 2'b10, "R4 arithmetic shift negative");
      issue(11, 8'h80, 9, 1'b1, 2'b01, "R4 logical shift beyond width");
      issue(17, 0, 0, 1'b1, 2'b01, "R10 move keeps flags");
      issue(16, 0, 0, 1'b1, 2'b01, "R10 decrement keeps flags");

      // R1: reset again from a nonzero flag state
      issue(1, 0, 1, 1'b1, 2'b10, "R7 subtract negative");
      @(negedge clk_i);
      valid_i = 1'b0;
      rst_ni = 1'b0;
      @(posedge clk_i);
      #2;
      check_flags(2'b00, "R1 reset after use");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule